// File: doc/BRIEF.md
# Programmable Master Video Sync Generator

This block is the timing master of a standard-definition video encoder. It runs from the 27 MHz sample clock and keeps a pixel counter and a line counter for either 525-line/60 Hz or 625-line/50 Hz scanning. Each format can be interlaced, with two fields, or progressive, with a short single-field frame. The two counters are decoded into horizontal sync, vertical sync, a field indicator, a composite sync and horizontal and vertical blanking flags.

Configuration arrives as static parallel inputs. The inputs pick the line standard, the scan type, a signed horizontal sync phase, one polarity for each sync signal and the routing of two shared output pins. One pin carries either vertical sync or the field signal. The other carries either the field signal or composite sync. Configuration is applied while the block is held in reset.

All outputs are combinational decodes of the counter registers. After reset is released the counters stand at pixel 0 of line 1, and they advance by one pixel on every clock.

Top module: `raster_sync_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the counters are at pixel 0 of line 1. In that state vblank_o=1 and hblank_o=1. With phase code 4 and negative polarity, hsync_o=0 (sync asserted).
- R2: A line lasts LINE_CLKS_525 clocks in 525 mode (cfg_std625=0) and LINE_CLKS_625 clocks in 625 mode (cfg_std625=1). Lines are numbered from 1. An interlaced frame (cfg_prog=0) has 525 or 625 lines. A progressive frame (cfg_prog=1) has 262 or 312 lines. After the last line the count returns to line 1.
- R3: hblank_o is 1 when the pixel index is below HBLK (HBLK_525 or HBLK_625) or at or above HBLK+ACTIVE_CLKS. It is 0 otherwise.
- R4: Horizontal sync is active for HSYNC_CLKS clocks per line. The phase code c on cfg_hphase delays it by 4-c clocks: code 0 gives +4 and code 7 gives -3. Sync is active when (pixel-(4-c)) modulo the line length is below HSYNC_CLKS.
- R5: Vertical sync in field 1, and in progressive mode, covers three whole lines starting at line 4 (525) or line 1 (625). Field-2 vertical sync lasts three lines. It starts at the half-line point of line 266 (525) or line 313 (625), so it begins half a line later than the field-1 pulse.
- R6: The field-2 indicator is set in interlaced mode on lines 264 and above (525) or 313 and above (625). It is always clear in progressive mode.
- R7: vblank_o is 1 on lines 1-19 and 264-282 in 525 mode. In 625 mode it is 1 on lines 1-22, 311-335 and 624-625. In progressive mode only the first range applies.
- R8: When cfg_hpol or cfg_vpol is 0, the corresponding sync is driven low while active. When it is 1, that sync is driven high while active. With cfg_fpol=0 the field signal is low in field 1. With cfg_fpol=1 it is high in field 1.
- R9: Composite sync equals horizontal sync outside vertical sync and the inverse of horizontal sync inside vertical sync. It follows the horizontal sync polarity.
- R10: vf_sync_o carries vertical sync when cfg_vf_sel=0 and the field signal when cfg_vf_sel=1. cf_sync_o carries the field signal when cfg_cf_sel=0 and composite sync when cfg_cf_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_std625 | input | 1 | 0: 525/60, 1: 625/50 |
| cfg_prog | input | 1 | 0: interlaced, 1: progressive |
| cfg_hphase | input | 3 | Horizontal sync phase code, delay = 4 - code |
| cfg_hpol | input | 1 | Horizontal and composite sync polarity, 1 = positive |
| cfg_vpol | input | 1 | Vertical sync polarity, 1 = positive |
| cfg_fpol | input | 1 | 1: field 1 driven high |
| cfg_vf_sel | input | 1 | 0: vertical sync on vf_sync_o, 1: field signal |
| cfg_cf_sel | input | 1 | 0: field signal on cf_sync_o, 1: composite sync |
| hsync_o | output | 1 | Horizontal sync |
| vf_sync_o | output | 1 | Vertical sync or field signal |
| cf_sync_o | output | 1 | Field signal or composite sync |
| vblank_o | output | 1 | Vertical blanking flag |
| hblank_o | output | 1 | Horizontal blanking flag |

## Verification
The assertions check the following on every cycle:
- The pixel and line counters stay inside the range of the selected format.
- The pixel count wraps to zero after the last pixel of a line.
- Vertical sync falls only inside vertical blanking.
- Horizontal sync falls only inside horizontal blanking.
- The field indicator changes only at a line start.

Some behaviour is visible only in the bench's scenarios, where a behavioural model is compared with the outputs on every clock across whole frames. These are the exact pulse positions, the half-line offset of the field-2 pulse, the phase shifts at both ends of the code range, the polarity and routing combinations, and the frame lengths of all four scan formats.

// File: rtl/raster_pkg.sv
package raster_pkg;
    // line counts per frame
    localparam int LINES_525 = 525;
    localparam int LINES_625 = 625;
    localparam int PROG_525  = 262;
    localparam int PROG_625  = 312;
    // first line of field 2
    localparam int F2_525 = 264;
    localparam int F2_625 = 313;
    // vertical sync placement
    localparam int VS1_525  = 4;
    localparam int VS1_625  = 1;
    localparam int VS2_525  = 266;
    localparam int VS2_625  = 313;
    localparam int VS_LINES = 3;
    // vertical blanking ranges
    localparam int VBA_END_525 = 19;
    localparam int VBB_BEG_525 = 264;
    localparam int VBB_END_525 = 282;
    localparam int VBA_END_625 = 22;
    localparam int VBB_BEG_625 = 311;
    localparam int VBB_END_625 = 335;
    localparam int VBW_BEG_625 = 624;
    localparam int LN_W = $clog2(LINES_625 + 1);

    typedef struct packed {
        logic hs;
        logic vs;
        logic fld2;
        logic vb;
        logic hb;
    } raw_flags_t;
endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int PIX_W    = 11,
    parameter int LINE_525 = 1716,
    parameter int LINE_625 = 1728
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             std625,
    input  logic             prog,
    output logic [PIX_W-1:0] pix_o,
    output logic [LN_W-1:0]  line_o
);
    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [LN_W-1:0]  line;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [PIX_W-1:0] last_pix;
    logic [LN_W-1:0]  last_line;

    always_comb begin
        last_pix  = std625 ? PIX_W'(LINE_625 - 1) : PIX_W'(LINE_525 - 1);
        if (prog) last_line = std625 ? LN_W'(PROG_625) : LN_W'(PROG_525);
        else      last_line = std625 ? LN_W'(LINES_625) : LN_W'(LINES_525);
        cnt_d = cnt_q;
        if (cnt_q.pix >= last_pix) begin
            cnt_d.pix  = '0;
            cnt_d.line = (cnt_q.line >= last_line) ? LN_W'(1) : cnt_q.line + LN_W'(1);
        end else begin
            cnt_d.pix = cnt_q.pix + PIX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.pix  <= '0;
            cnt_q.line <= LN_W'(1);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pix_o  = cnt_q.pix;
    assign line_o = cnt_q.line;

    // R2
    pix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.pix <= last_pix);
    // R2
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.line >= LN_W'(1)) && (cnt_q.line <= last_line));
    // R2
    pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.pix == last_pix) |=> (cnt_q.pix == '0));
endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
#(
    parameter int PIX_W       = 11,
    parameter int LINE_525    = 1716,
    parameter int LINE_625    = 1728,
    parameter int HBLK_525    = 242,
    parameter int HBLK_625    = 262,
    parameter int ACTIVE_CLKS = 1440,
    parameter int HSYNC_CLKS  = 128
) (
    input  logic             std625,
    input  logic             prog,
    input  logic [2:0]       hphase,
    input  logic [PIX_W-1:0] pix,
    input  logic [LN_W-1:0]  line,
    output raw_flags_t       flags_o
);
    int len, half, shift, ppos, pshift, ln, hbl, vs1, vs2, f2;

    always_comb begin
        len    = std625 ? LINE_625 : LINE_525;
        half   = len / 2;
        hbl    = std625 ? HBLK_625 : HBLK_525;
        vs1    = std625 ? VS1_625 : VS1_525;
        vs2    = std625 ? VS2_625 : VS2_525;
        f2     = std625 ? F2_625 : F2_525;
        shift  = 4 - int'(hphase);
        ppos   = int'(pix);
        ln     = int'(line);
        pshift = ppos - shift;
        if (pshift < 0)         pshift = pshift + len;
        else if (pshift >= len) pshift = pshift - len;

        flags_o.hs = (pshift < HSYNC_CLKS);
        flags_o.hb = (ppos < hbl) || (ppos >= hbl + ACTIVE_CLKS);
        flags_o.fld2 = !prog && (ln >= f2);

        flags_o.vs = (ln >= vs1) && (ln < vs1 + VS_LINES);
        if (!prog) begin
            flags_o.vs = flags_o.vs
                || ((ln == vs2) && (ppos >= half))
                || ((ln > vs2) && (ln < vs2 + VS_LINES))
                || ((ln == vs2 + VS_LINES) && (ppos < half));
        end

        if (std625) begin
            flags_o.vb = (ln <= VBA_END_625);
            if (!prog) flags_o.vb = flags_o.vb || (ln >= VBW_BEG_625)
                || ((ln >= VBB_BEG_625) && (ln <= VBB_END_625));
        end else begin
            flags_o.vb = (ln <= VBA_END_525);
            if (!prog) flags_o.vb = flags_o.vb
                || ((ln >= VBB_BEG_525) && (ln <= VBB_END_525));
        end
    end
endmodule

// File: rtl/raster_drive.sv
module raster_drive
    import raster_pkg::*;
(
    input  raw_flags_t flags,
    input  logic       hpol,
    input  logic       vpol,
    input  logic       fpol,
    input  logic       vf_sel,
    input  logic       cf_sel,
    output logic       hsync_o,
    output logic       vf_sync_o,
    output logic       cf_sync_o,
    output logic       vblank_o,
    output logic       hblank_o
);
    logic cs_raw, vs_lvl, cs_lvl, fld_lvl;

    always_comb begin
        cs_raw    = flags.vs ? !flags.hs : flags.hs;
        hsync_o   = hpol ? flags.hs : !flags.hs;
        cs_lvl    = hpol ? cs_raw : !cs_raw;
        vs_lvl    = vpol ? flags.vs : !flags.vs;
        fld_lvl   = fpol ? !flags.fld2 : flags.fld2;
        vf_sync_o = vf_sel ? fld_lvl : vs_lvl;
        cf_sync_o = cf_sel ? cs_lvl : fld_lvl;
        vblank_o  = flags.vb;
        hblank_o  = flags.hb;
    end
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import raster_pkg::*;
#(
    parameter int LINE_CLKS_525 = 1716,
    parameter int LINE_CLKS_625 = 1728,
    parameter int HBLK_525      = 242,
    parameter int HBLK_625      = 262,
    parameter int ACTIVE_CLKS   = 1440,
    parameter int HSYNC_CLKS    = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_std625,
    input  logic       cfg_prog,
    input  logic [2:0] cfg_hphase,
    input  logic       cfg_hpol,
    input  logic       cfg_vpol,
    input  logic       cfg_fpol,
    input  logic       cfg_vf_sel,
    input  logic       cfg_cf_sel,
    output logic       hsync_o,
    output logic       vf_sync_o,
    output logic       cf_sync_o,
    output logic       vblank_o,
    output logic       hblank_o
);
    localparam int MAX_LINE = (LINE_CLKS_625 > LINE_CLKS_525) ? LINE_CLKS_625 : LINE_CLKS_525;
    localparam int PIX_W    = $clog2(MAX_LINE + 1);

    logic [PIX_W-1:0] pix;
    logic [LN_W-1:0]  line;
    raw_flags_t       flags;

    raster_counter #(
        .PIX_W(PIX_W), .LINE_525(LINE_CLKS_525), .LINE_625(LINE_CLKS_625)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .std625(cfg_std625), .prog(cfg_prog),
        .pix_o(pix), .line_o(line)
    );

    raster_decode #(
        .PIX_W(PIX_W), .LINE_525(LINE_CLKS_525), .LINE_625(LINE_CLKS_625),
        .HBLK_525(HBLK_525), .HBLK_625(HBLK_625),
        .ACTIVE_CLKS(ACTIVE_CLKS), .HSYNC_CLKS(HSYNC_CLKS)
    ) u_dec (
        .std625(cfg_std625), .prog(cfg_prog), .hphase(cfg_hphase),
        .pix(pix), .line(line), .flags_o(flags)
    );

    raster_drive u_drv (
        .flags(flags), .hpol(cfg_hpol), .vpol(cfg_vpol), .fpol(cfg_fpol),
        .vf_sel(cfg_vf_sel), .cf_sel(cfg_cf_sel),
        .hsync_o(hsync_o), .vf_sync_o(vf_sync_o), .cf_sync_o(cf_sync_o),
        .vblank_o(vblank_o), .hblank_o(hblank_o)
    );

    // R5 R7
    vs_in_vb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags.vs |-> flags.vb);
    // R3 R4
    hs_in_hb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags.hs |-> flags.hb);
    // R6
    field_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags.fld2) |-> (pix == '0));
endmodule

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb;
    localparam int L525 = 60;
    localparam int L625 = 64;
    localparam int HB525 = 10;
    localparam int HB625 = 12;
    localparam int ACT = 40;
    localparam int HSW = 6;
    localparam int WATCHDOG_CYC = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_std625 = 1'b0, cfg_prog = 1'b0;
    logic [2:0] cfg_hphase = 3'd4;
    logic cfg_hpol = 1'b0, cfg_vpol = 1'b0, cfg_fpol = 1'b0;
    logic cfg_vf_sel = 1'b0, cfg_cf_sel = 1'b1;
    logic hsync_o, vf_sync_o, cf_sync_o, vblank_o, hblank_o;

    int errors = 0;
    int checks = 0;
    int mpix, mline;
    bit done = 1'b0;

    always #5 clk = ~clk;

    raster_sync_gen #(
        .LINE_CLKS_525(L525), .LINE_CLKS_625(L625),
        .HBLK_525(HB525), .HBLK_625(HB625),
        .ACTIVE_CLKS(ACT), .HSYNC_CLKS(HSW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_std625(cfg_std625), .cfg_prog(cfg_prog),
        .cfg_hphase(cfg_hphase), .cfg_hpol(cfg_hpol), .cfg_vpol(cfg_vpol),
        .cfg_fpol(cfg_fpol), .cfg_vf_sel(cfg_vf_sel), .cfg_cf_sel(cfg_cf_sel),
        .hsync_o(hsync_o), .vf_sync_o(vf_sync_o), .cf_sync_o(cf_sync_o),
        .vblank_o(vblank_o), .hblank_o(hblank_o)
    );

    task automatic check1(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s line=%0d pix=%0d actual=%b expected=%b",
                     tag, name, mline, mpix, act, exp);
        end
    endtask

    // Behavioural expectation for the current model position
    task automatic compare(input bit at_reset);
        int len, half, d, p, hb_end;
        bit hs, vs, f2, vb, hb, cs, hs_l, vs_l, cs_l, f_l, vf, cf;
        len  = cfg_std625 ? L625 : L525;
        half = len / 2;
        d    = 4 - int'(cfg_hphase);
        p    = ((mpix - d) % len + len) % len;
        hs   = (p < HSW);                                           // R4
        hb_end = (cfg_std625 ? HB625 : HB525);
        hb   = (mpix < hb_end) || (mpix >= hb_end + ACT);           // R3
        f2   = !cfg_prog && (mline >= (cfg_std625 ? 313 : 264));    // R6
        if (cfg_std625) begin
            vs = (mline >= 1 && mline <= 3);
            if (!cfg_prog) vs = vs || (mline == 313 && mpix >= half) ||
                (mline == 314) || (mline == 315) || (mline == 316 && mpix < half);
            vb = (mline <= 22);
            if (!cfg_prog) vb = vb || (mline >= 624) || (mline >= 311 && mline <= 335);
        end else begin
            vs = (mline >= 4 && mline <= 6);
            if (!cfg_prog) vs = vs || (mline == 266 && mpix >= half) ||
                (mline == 267) || (mline == 268) || (mline == 269 && mpix < half);
            vb = (mline <= 19);
            if (!cfg_prog) vb = vb || (mline >= 264 && mline <= 282);
        end
        cs   = vs ? !hs : hs;                                       // R9
        hs_l = cfg_hpol ? hs : !hs;                                 // R8
        cs_l = cfg_hpol ? cs : !cs;
        vs_l = cfg_vpol ? vs : !vs;
        f_l  = cfg_fpol ? !f2 : f2;
        vf   = cfg_vf_sel ? f_l : vs_l;                             // R10
        cf   = cfg_cf_sel ? cs_l : f_l;
        if (at_reset) begin
            check1("R1", "hsync_o", hsync_o, hs_l);
            check1("R1", "vblank_o", vblank_o, 1'b1);
            check1("R1", "hblank_o", hblank_o, 1'b1);
        end
        check1("R2 R4 R8", "hsync_o", hsync_o, hs_l);
        check1("R5 R6 R8 R10", "vf_sync_o", vf_sync_o, vf);
        check1("R6 R9 R10", "cf_sync_o", cf_sync_o, cf);
        check1("R7", "vblank_o", vblank_o, vb);
        check1("R3", "hblank_o", hblank_o, hb);
    endtask

    // R2: model line counting
    task automatic advance();
        int len, last;
        len  = cfg_std625 ? L625 : L525;
        last = cfg_prog ? (cfg_std625 ? 312 : 262) : (cfg_std625 ? 625 : 525);
        if (mpix == len - 1) begin
            mpix  = 0;
            mline = (mline >= last) ? 1 : mline + 1;
        end else begin
            mpix = mpix + 1;
        end
    endtask

    task automatic run_case(input logic std, input logic prg, input logic [2:0] ph,
                            input logic hp, input logic vp, input logic fp,
                            input logic vfs, input logic cfs, input int ncyc);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_std625 = std; cfg_prog = prg; cfg_hphase = ph;
        cfg_hpol = hp; cfg_vpol = vp; cfg_fpol = fp;
        cfg_vf_sel = vfs; cfg_cf_sel = cfs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mpix = 0;
        mline = 1;
        compare(ph == 3'd4 && !hp);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            advance();
            compare(1'b0);
        end
    endtask

    initial begin
        // 525 interlaced, zero phase, negative syncs, composite on cf pin (R1 R5 R9)
        run_case(1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 525 * L525 + 100);
        // 625 interlaced, +4 phase, positive syncs, field on both pins (R4 R8 R10)
        run_case(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 625 * L625 + 100);
        // 525 progressive, -3 phase, short frame (R2 R6 R7)
        run_case(1'b0, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 262 * L525 + 200);
        // 625 progressive, +1 phase, field routed to vf pin
        run_case(1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 312 * L625 + 200);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule